// File: doc/BRIEF.md
# Debounced Toggle Pause Controller

This block takes the raw level of a single-pole push switch and turns each physical press into exactly one clean inversion of a run flag. That flag gates a free-running pair of decimal digits, so the first press freezes the displayed count and the next press lets it continue from the frozen value, in the way a bedside lamp switch alternates on and off.

The raw level first crosses into the clock domain through a small synchronizer chain. A saturating mask timer is held cleared for as long as the switch is active. Once released, it needs 2^(TIMER_BITS-1) quiet cycles before its top bit sets again. A press is recognised on the cycle in which that top bit falls. The first contact therefore acts at once, and every bounce that follows inside the mask window lands on an already-cleared timer and goes unseen. The digits advance on a slow tick taken from a free-running prescaler. The upper digit moves only when the lower digit is at its last value and a tick arrives while running.

Top module: `pause_toggle_ctrl`

## Requirements
- R1: Each `press_pulse` inverts `run_en`, and the new value is visible on the clock edge that ends the pulse.
- R2: A synchronous reset forces `run_en` to 1, both digits to 0 and `press_pulse` to 0. With the switch idle, no `press_pulse` ever follows reset.
- R3: A burst of switch activity produces exactly one `press_pulse` if none of its inactive gaps lasts `2^(TIMER_BITS-1)` cycles. A press held active for any length of time also produces exactly one.
- R4: `press_pulse` is never high for two cycles in a row.
- R5: While `run_en` is 0 both digits hold their value. After a resume they continue from the held value and do not restart from zero.
- R6: The prescaler is cleared by reset and fires a tick in every cycle where its `PRESCALE_BITS`-wide count is all ones. On a tick while running, `digit_lo` advances by one and wraps from `DIGIT_MAX` to 0. It never exceeds `DIGIT_MAX`.
- R7: `digit_hi` advances, wrapping from `DIGIT_MAX` to 0, only on a tick while running with `digit_lo` at `DIGIT_MAX`.
- R8: With the default polarity a `sw_raw` level of 1 means pressed. When the mask timer is saturated, `press_pulse` is high during the cycle after the third rising edge that samples `sw_raw` active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 1 | Raw, unsynchronised switch level |
| run_en | output | 1 | Count-enable flag toggled by each accepted press |
| press_pulse | output | 1 | One-cycle marker of an accepted press |
| digit_lo | output | DIGIT_W | Lower decimal digit |
| digit_hi | output | DIGIT_W | Upper decimal digit |

## Verification
The switch is driven with three patterns: a short press, a press wrapped in chattering contacts, and a long steady hold. The chatter separates a design that masks bounce from one that toggles on every contact. The long hold separates a timer that is kept cleared while the switch is active from one that restarts after one window. Long running stretches check the carry into the upper digit and its wrap. Paused stretches that cover many ticks show whether the digits truly freeze and then resume from where they stopped. A reset in the middle of a run, and pairs of presses closely spaced, complete the set.

// File: rtl/pt_pkg.sv
package pt_pkg;
   typedef enum logic {
      SW_ACT_LOW  = 1'b0,
      SW_ACT_HIGH = 1'b1
   } sw_pol_e;
endpackage

// File: rtl/pt_sync.sv
module pt_sync
   import pt_pkg::*;
#(
   parameter int      STAGES = 2,
   parameter sw_pol_e POL    = SW_ACT_HIGH
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic active
);
   localparam logic IDLE_LVL = (POL == SW_ACT_HIGH) ? 1'b0 : 1'b1;

   if (STAGES < 2) begin : g_bad
      $error("pt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE_LVL}};
      else     chain <= {chain[STAGES-2:0], raw};
   end

   if (POL == SW_ACT_HIGH) begin : g_hi
      assign active = chain[STAGES-1];
   end else begin : g_lo
      assign active = ~chain[STAGES-1];
   end
endmodule

// File: rtl/pt_bounce_mask.sv
module pt_bounce_mask #(
   parameter int TIMER_BITS = 23
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   output logic press
);
   localparam int MSB = TIMER_BITS - 1;
   localparam logic [TIMER_BITS-1:0] SAT_VAL = {1'b1, {(TIMER_BITS-1){1'b0}}};
   localparam logic [TIMER_BITS-1:0] ONE     = {{(TIMER_BITS-1){1'b0}}, 1'b1};

   if (TIMER_BITS < 2) begin : g_bad
      $error("pt_bounce_mask: TIMER_BITS must be at least 2");
   end

   logic [TIMER_BITS-1:0] timer;
   logic                  msb_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         timer <= SAT_VAL;
         msb_q <= 1'b1;
      end else begin
         msb_q <= timer[MSB];
         if (active)          timer <= '0;
         else if (!timer[MSB]) timer <= timer + ONE;
      end
   end

   assign press = msb_q & ~timer[MSB];
endmodule

// File: rtl/pt_tick_div.sv
module pt_tick_div #(
   parameter int BITS = 24
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam logic [BITS-1:0] ONE = {{(BITS-1){1'b0}}, 1'b1};

   if (BITS < 1) begin : g_bad
      $error("pt_tick_div: BITS must be positive");
   end

   logic [BITS-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + ONE;
   end

   assign tick = &cnt;
endmodule

// File: rtl/pt_digit_chain.sv
module pt_digit_chain #(
   parameter int DIGIT_W    = 4,
   parameter int DIGIT_MAX  = 9,
   parameter int NUM_DIGITS = 2
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                step,
   output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  digits
);
   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(DIGIT_MAX);
   localparam logic [DIGIT_W-1:0] ONE  = {{(DIGIT_W-1){1'b0}}, 1'b1};

   if (DIGIT_MAX < 1 || DIGIT_MAX >= (1 << DIGIT_W)) begin : g_bad
      $error("pt_digit_chain: DIGIT_MAX does not fit DIGIT_W");
   end

   logic [NUM_DIGITS:0] carry;
   assign carry[0] = step;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      logic at_last;
      assign at_last    = (digits[i] == LAST);
      assign carry[i+1] = carry[i] & at_last;

      always_ff @(posedge clk) begin
         if (rst)           digits[i] <= '0;
         else if (carry[i]) digits[i] <= at_last ? '0 : digits[i] + ONE;
      end
   end
endmodule

// File: rtl/pause_toggle_ctrl.sv
module pause_toggle_ctrl
   import pt_pkg::*;
#(
   parameter int      SYNC_STAGES   = 2,
   parameter sw_pol_e SW_POL        = SW_ACT_HIGH,
   parameter int      TIMER_BITS    = 23,
   parameter int      PRESCALE_BITS = 24,
   parameter int      DIGIT_W       = 4,
   parameter int      DIGIT_MAX     = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sw_raw,
   output logic               run_en,
   output logic               press_pulse,
   output logic [DIGIT_W-1:0] digit_lo,
   output logic [DIGIT_W-1:0] digit_hi
);
   localparam int NUM_DIGITS = 2;

   logic sw_active;
   logic tick;
   logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

   pt_sync #(.STAGES(SYNC_STAGES), .POL(SW_POL)) u_sync (
      .clk(clk), .rst(rst), .raw(sw_raw), .active(sw_active));

   pt_bounce_mask #(.TIMER_BITS(TIMER_BITS)) u_mask (
      .clk(clk), .rst(rst), .active(sw_active), .press(press_pulse));

   always_ff @(posedge clk) begin
      if (rst)              run_en <= 1'b1;
      else if (press_pulse) run_en <= ~run_en;
   end

   pt_tick_div #(.BITS(PRESCALE_BITS)) u_div (
      .clk(clk), .rst(rst), .tick(tick));

   pt_digit_chain #(.DIGIT_W(DIGIT_W), .DIGIT_MAX(DIGIT_MAX),
                    .NUM_DIGITS(NUM_DIGITS)) u_digits (
      .clk(clk), .rst(rst), .step(tick & run_en), .digits(digits));

   assign digit_lo = digits[0];
   assign digit_hi = digits[1];
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
   parameter int DIGIT_W   = 4,
   parameter int DIGIT_MAX = 9
) (
   input logic               clk,
   input logic               rst,
   input logic               run_en,
   input logic               press_pulse,
   input logic [DIGIT_W-1:0] digit_lo,
   input logic [DIGIT_W-1:0] digit_hi
);
   localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(DIGIT_MAX);

   // R4
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      press_pulse |=> !press_pulse);

   // R1
   en_change_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && run_en != $past(run_en)) |-> $past(press_pulse));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !run_en |=> ($stable(digit_lo) && $stable(digit_hi)));

   // R6
   lo_range_chk: assert property (@(posedge clk) disable iff (rst)
      digit_lo <= LAST && digit_hi <= LAST);

   // R7
   hi_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && digit_hi != $past(digit_hi)) |->
         ($past(digit_lo) == LAST && digit_lo == '0 && $past(run_en)));
endmodule

bind pause_toggle_ctrl pt_checker #(.DIGIT_W(DIGIT_W), .DIGIT_MAX(DIGIT_MAX)) u_chk (
   .clk(clk), .rst(rst), .run_en(run_en), .press_pulse(press_pulse),
   .digit_lo(digit_lo), .digit_hi(digit_hi));

// File: tb/sim_pause_toggle_ctrl.sv
module sim_pause_toggle_ctrl;
   localparam int TB   = 4;
   localparam int PB   = 3;
   localparam int DW   = 4;
   localparam int DMAX = 9;
   localparam int PMAX = (1 << PB) - 1;

   logic clk = 1'b0, rst = 1'b1, sw_raw = 1'b0;
   logic run_en, press_pulse;
   logic [DW-1:0] digit_lo, digit_hi;

   pause_toggle_ctrl #(.TIMER_BITS(TB), .PRESCALE_BITS(PB), .DIGIT_W(DW),
                       .DIGIT_MAX(DMAX)) u0 (
      .clk(clk), .rst(rst), .sw_raw(sw_raw), .run_en(run_en),
      .press_pulse(press_pulse), .digit_lo(digit_lo), .digit_hi(digit_hi));

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected digit model built from R6/R7
   int  m_pre = 0, m_lo = 0, m_hi = 0;
   bit  m_wrapped = 0;
   always @(posedge clk) begin
      if (rst) begin
         m_pre <= 0; m_lo <= 0; m_hi <= 0;
      end else begin
         m_pre <= (m_pre == PMAX) ? 0 : m_pre + 1;
         if (m_pre == PMAX && run_en) begin
            if (m_lo == DMAX) begin
               m_lo <= 0;
               if (m_hi == DMAX) begin m_hi <= 0; m_wrapped <= 1; end
               else m_hi <= m_hi + 1;
            end else m_lo <= m_lo + 1;
         end
      end
   end

   // scoreboard
   bit exp_q[$];
   bit exp_state = 1'b1;
   bit pend = 0, pend_val = 0;
   bit mon_on = 0;

   always @(negedge clk) begin
      if (mon_on && !rst) begin
         // R5 R6 R7 digits follow model
         check(digit_lo == DW'(m_lo), "R6 digit_lo", digit_lo, m_lo);
         check(digit_hi == DW'(m_hi), "R7 digit_hi", digit_hi, m_hi);
         if (pend) begin
            check(run_en == pend_val, "R1 run_en after press", run_en, pend_val);
            pend = 0;
         end
         if (press_pulse) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected press", 1, 0);
            else begin
               pend_val = exp_q.pop_front();
               pend = 1;
            end
         end
      end
   end

   task automatic burst(input int hold, input bit chatter);
      exp_state = ~exp_state;
      exp_q.push_back(exp_state);
      @(negedge clk) sw_raw = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(press_pulse == 1'b1, "R8 press latency", press_pulse, 1);
      if (chatter) begin
         sw_raw = 1'b0; repeat (2) @(negedge clk);
         sw_raw = 1'b1; repeat (1) @(negedge clk);
         sw_raw = 1'b0; repeat (3) @(negedge clk);
         sw_raw = 1'b1;
      end
      repeat (hold) @(negedge clk);
      if (chatter) begin
         sw_raw = 1'b0; repeat (4) @(negedge clk);
         sw_raw = 1'b1; repeat (2) @(negedge clk);
      end
      sw_raw = 1'b0;
      repeat (20) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      check(0, "watchdog", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      check(run_en == 1'b1, "R2 run_en reset", run_en, 1);
      check(digit_lo == 0 && digit_hi == 0, "R2 digits reset", {digit_hi, digit_lo}, 0);
      check(press_pulse == 1'b0, "R2 press reset", press_pulse, 0);
      rst = 1'b0;
      mon_on = 1;
      repeat (40) @(negedge clk);
      burst(4, 1'b0);                 // R1 plain press -> paused
      repeat (120) @(negedge clk);    // R5 held over many ticks
      burst(50, 1'b0);                // R3 long hold -> resume
      burst(3, 1'b1);                 // R3 chattering press -> pause
      repeat (60) @(negedge clk);
      burst(5, 1'b1);                 // resume
      repeat (1000) @(negedge clk);   // R7 carry and wrap
      check(m_wrapped == 1'b1, "R7 upper digit wrapped", m_wrapped, 1);
      burst(2, 1'b0);
      burst(2, 1'b0);                 // R1 two closely spaced presses
      check(run_en == 1'b1, "R1 double toggle", run_en, 1);
      repeat (30) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(run_en == 1'b1, "R2 run_en mid reset", run_en, 1);
      check(digit_lo == 0 && digit_hi == 0, "R2 digits mid reset", {digit_hi, digit_lo}, 0);
      rst = 1'b0;
      exp_state = 1'b1;
      repeat (60) @(negedge clk);     // R2 no press after reset
      check(exp_q.size() == 0, "R3 one pulse per burst", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule